// File: doc/BRIEF.md
# Half-Bridge Driver Fault Supervisor

This block is the protection controller for a three-phase half-bridge gate driver. It watches raw comparator flags: a per-phase over-current flag, supply under- and over-voltage, charge-pump under-voltage, an over-temperature warning and an over-temperature shutdown. When one of them asserts, it turns off every high-side and low-side gate demand. It also pulls an active-low fault line low. The block releases the gates by itself once a retry interval has passed.

Over-current goes through two filters before it counts. The first is a blanking window that opens after each switching event. The second is a deglitch window that needs the flag to stay high without a break. The active-low sleep input is classified by how long it stays low. A short glitch does nothing. A pulse of medium width clears latched faults. A long low level puts the block to sleep.

Every time window is a cycle count derived from the `CLK_HZ` parameter. The defaults are: blanking 0.7 µs, deglitch 0.6 µs, retry 5 ms slow or 0.5 ms fast, and a clear pulse of 15 µs to 50 µs. For each window, BLANK, DEG, SLOW, FAST, SMIN and SMAX below mean its cycle count.

Top module: `mfault_sup`

## Requirements
- R1: The clock edge that samples `switchEvt` high starts a blanking window. For the BLANK edges that follow it, the over-current flags are not counted, and any partial count is discarded.
- R2: A phase over-current flag must be sampled high on DEG consecutive unblanked edges. The gates then turn off at the next edge, and `faultN` falls at that same edge.
- R3: Each of `uvRaw`, `ovRaw`, `cpuvRaw` and `otsRaw`, when sampled high on a single edge, turns off all gates at that edge and pulls `faultN` low.
- R4: The gates are re-enabled exactly FAST cycles after the last edge that saw any fault source active when `retryFast`=1, and SLOW cycles after it when `retryFast`=0. A fault seen again during the interval restarts it.
- R5: `faultN` is 0 for as long as a fault is latched, and returns to 1 when the fault is released.
- R6: With `otwEn`=1, `otwRaw`=1 drives `faultN` to 0 in the same cycle while the gates stay enabled. With `otwEn`=0, `otwRaw` has no effect.
- R7: A low pulse on `sleepN` that lasts fewer than SMIN sampled edges is ignored, and a latched fault stays latched.
- R8: A low pulse on `sleepN` that lasts between SMIN and SMAX sampled edges, inclusive, clears a latched fault at the edge that first samples `sleepN` high again.
- R9: When `sleepN` has been low for more than SMAX edges, `sleeping`=1 and the gates are off. Waking then clears all fault state: one edge after `sleepN` returns high, `sleeping`=0, `faultN`=1 and the gates are enabled.
- R10: When the block is enabled, `hiGate`/`loGate` equal `hiDemand`/`loDemand` bit by bit (bit i belongs to phase i). When it is disabled, both are all zero.
- R11: After reset the gates follow the demands, `faultN`=1 and `sleeping`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| switchEvt | input | 1 | Outputs have just switched; starts blanking |
| ocRaw | input | NUM_PH | Per-phase over-current comparator flags |
| uvRaw | input | 1 | Supply under-voltage flag |
| ovRaw | input | 1 | Supply over-voltage flag |
| cpuvRaw | input | 1 | Charge-pump under-voltage flag |
| otsRaw | input | 1 | Over-temperature shutdown flag |
| otwRaw | input | 1 | Over-temperature warning flag |
| otwEn | input | 1 | Lets the warning reach `faultN` |
| retryFast | input | 1 | 1 selects the fast retry interval, 0 the slow one |
| sleepN | input | 1 | Active-low sleep / fault-clear pin |
| hiDemand | input | NUM_PH | High-side gate demands |
| loDemand | input | NUM_PH | Low-side gate demands |
| hiGate | output | NUM_PH | Gated high-side drives |
| loGate | output | NUM_PH | Gated low-side drives |
| faultN | output | 1 | Active-low fault indicator |
| sleeping | output | 1 | Sleep state |

## Verification
Each result has a fixed due time.
- A level fault takes effect at the edge that samples it.
- Over-current takes effect one edge after the DEG-th consecutive unblanked sample.
- Release comes exactly FAST or SLOW edges after the last active sample.
- A clear pulse acts at the edge that sees `sleepN` high again.
- The warning path is combinational.

The bench drives inputs on falling edges and counts edges with explicit waits. It checks each outcome one edge before it is due, to confirm it has not happened early, and again at the edge where it is due. Each window is also probed one count below its threshold and exactly at it.

// File: rtl/mfault_sup_pkg.sv
package mfault_sup_pkg;
  typedef struct packed {
    logic retryStart;
    logic retryFast;
  } ctlStrobe_t;
endpackage

// File: rtl/mfault_sup_dp.sv
module mfault_sup_dp
  import mfault_sup_pkg::*;
#(
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int unsigned NUM_PH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              switchEvt,
  input  logic [NUM_PH-1:0] ocRaw,
  input  logic              sleepN,
  input  ctlStrobe_t        ctl,
  output logic              ocDet,
  output logic              retryDone,
  output logic              clrPulse,
  output logic              asleep
);
  localparam longint unsigned HZ = 64'(CLK_HZ);
  localparam int unsigned BLANK_CYC = int'((HZ * 7 + 9_999_999) / 10_000_000);
  localparam int unsigned DEG_CYC   = int'((HZ * 6 + 9_999_999) / 10_000_000);
  localparam int unsigned SLOW_CYC  = int'(HZ / 200);
  localparam int unsigned FAST_CYC  = int'(HZ / 2000);
  localparam int unsigned SMIN_CYC  = int'((HZ * 15 + 999_999) / 1_000_000);
  localparam int unsigned SMAX_CYC  = int'(HZ * 50 / 1_000_000);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int DW = $clog2(DEG_CYC + 1);
  localparam int TW = $clog2(SLOW_CYC);
  localparam int SW = $clog2(SMAX_CYC + 2);
  localparam logic [BW-1:0] BLANK_V = BW'(BLANK_CYC);
  localparam logic [DW-1:0] DEG_V   = DW'(DEG_CYC);
  localparam logic [TW-1:0] SLOW_V  = TW'(SLOW_CYC - 1);
  localparam logic [TW-1:0] FAST_V  = TW'(FAST_CYC - 1);
  localparam logic [SW-1:0] SMIN_V  = SW'(SMIN_CYC);
  localparam logic [SW-1:0] SMAX_V  = SW'(SMAX_CYC);

  // blanking window after a switching event
  logic [BW-1:0] blankCnt;
  logic blanking;
  assign blanking = (blankCnt != '0);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blankCnt <= '0;
    else if (switchEvt) blankCnt <= BLANK_V;
    else if (blanking) blankCnt <= blankCnt - BW'(1);
  end

  // per-phase deglitch counters
  logic [NUM_PH-1:0] phHit;
  for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
    logic [DW-1:0] runCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) runCnt <= '0;
      else if (ocRaw[g] && !blanking) runCnt <= (runCnt == DEG_V) ? runCnt : runCnt + DW'(1);
      else runCnt <= '0;
    end
    assign phHit[g] = (runCnt == DEG_V);
    a_r1_blank_clears: assert property (@(posedge clk) disable iff (!rstN)
      blanking |=> (runCnt == '0));
  end
  assign ocDet = |phHit;

  // retry interval timer
  logic [TW-1:0] retryCnt;
  logic retryRun, fastSel;
  assign retryDone = retryRun && (retryCnt == (fastSel ? FAST_V : SLOW_V));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryRun <= 1'b0;
      retryCnt <= '0;
      fastSel  <= 1'b0;
    end else if (ctl.retryStart) begin
      retryRun <= 1'b1;
      retryCnt <= '0;
      fastSel  <= ctl.retryFast;
    end else if (retryDone) begin
      retryRun <= 1'b0;
    end else if (retryRun) begin
      retryCnt <= retryCnt + TW'(1);
    end
  end

  // sleep pin low-width classifier
  logic [SW-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (!sleepN) lowCnt <= (lowCnt > SMAX_V) ? lowCnt : lowCnt + SW'(1);
    else lowCnt <= '0;
  end
  assign clrPulse = sleepN && (lowCnt >= SMIN_V) && (lowCnt <= SMAX_V);
  assign asleep   = (lowCnt > SMAX_V);

  a_r2_det_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    ocDet |-> $past(|ocRaw));
  a_r8_clear_after_low: assert property (@(posedge clk) disable iff (!rstN)
    clrPulse |-> $past(!sleepN));
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    retryDone |=> !retryDone);
endmodule

// File: rtl/mfault_sup_ctl.sv
module mfault_sup_ctl
  import mfault_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ocDet,
  input  logic       uvRaw,
  input  logic       ovRaw,
  input  logic       cpuvRaw,
  input  logic       otsRaw,
  input  logic       otwRaw,
  input  logic       otwEn,
  input  logic       retryFast,
  input  logic       retryDone,
  input  logic       clrPulse,
  input  logic       asleep,
  output ctlStrobe_t ctl,
  output logic       faultActive,
  output logic       faultN,
  output logic       gateEn
);
  logic newFault;
  assign newFault = ocDet | uvRaw | ovRaw | cpuvRaw | otsRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultActive <= 1'b0;
    else if (asleep) faultActive <= 1'b0;
    else if (clrPulse) faultActive <= 1'b0;
    else if (newFault) faultActive <= 1'b1;
    else if (retryDone) faultActive <= 1'b0;
  end

  always_comb begin
    ctl.retryStart = newFault && !asleep && !clrPulse;
    ctl.retryFast  = retryFast;
  end

  assign faultN = !(faultActive || (otwEn && otwRaw));
  assign gateEn = !faultActive && !asleep;

  a_r3_level_latch: assert property (@(posedge clk) disable iff (!rstN)
    ((uvRaw || ovRaw || cpuvRaw || otsRaw) && !asleep && !clrPulse) |=> faultActive);
  a_r4_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (faultActive && !retryDone && !clrPulse && !asleep) |=> faultActive);
  a_r9_sleep_clears: assert property (@(posedge clk) disable iff (!rstN)
    asleep |=> !faultActive);
  a_r6_warn_no_shutdown: assert property (@(posedge clk) disable iff (!rstN)
    (otwRaw && !faultActive && !asleep) |-> gateEn);
endmodule

// File: rtl/mfault_sup.sv
module mfault_sup
  import mfault_sup_pkg::*;
#(
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int unsigned NUM_PH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              switchEvt,
  input  logic [NUM_PH-1:0] ocRaw,
  input  logic              uvRaw,
  input  logic              ovRaw,
  input  logic              cpuvRaw,
  input  logic              otsRaw,
  input  logic              otwRaw,
  input  logic              otwEn,
  input  logic              retryFast,
  input  logic              sleepN,
  input  logic [NUM_PH-1:0] hiDemand,
  input  logic [NUM_PH-1:0] loDemand,
  output logic [NUM_PH-1:0] hiGate,
  output logic [NUM_PH-1:0] loGate,
  output logic              faultN,
  output logic              sleeping
);
  ctlStrobe_t ctl;
  logic ocDet, retryDone, clrPulse, asleep, faultActive, gateEn;

  mfault_sup_dp #(.CLK_HZ(CLK_HZ), .NUM_PH(NUM_PH)) u_dp (
    .clk(clk), .rstN(rstN), .switchEvt(switchEvt), .ocRaw(ocRaw), .sleepN(sleepN),
    .ctl(ctl), .ocDet(ocDet), .retryDone(retryDone), .clrPulse(clrPulse), .asleep(asleep)
  );

  mfault_sup_ctl u_ctl (
    .clk(clk), .rstN(rstN), .ocDet(ocDet), .uvRaw(uvRaw), .ovRaw(ovRaw),
    .cpuvRaw(cpuvRaw), .otsRaw(otsRaw), .otwRaw(otwRaw), .otwEn(otwEn),
    .retryFast(retryFast), .retryDone(retryDone), .clrPulse(clrPulse), .asleep(asleep),
    .ctl(ctl), .faultActive(faultActive), .faultN(faultN), .gateEn(gateEn)
  );

  assign hiGate   = hiDemand & {NUM_PH{gateEn}};
  assign loGate   = loDemand & {NUM_PH{gateEn}};
  assign sleeping = asleep;

  a_r10_gates_off: assert property (@(posedge clk) disable iff (!rstN)
    !gateEn |-> (hiGate == '0 && loGate == '0));
  a_r5_fault_low: assert property (@(posedge clk) disable iff (!rstN)
    faultActive |-> !faultN);
endmodule

// File: tb/mfault_sup_bench.sv
`timescale 1ns/1ps
module mfault_sup_bench;
  localparam int unsigned HZ = 10_000_000;
  localparam int BLANK = 7, DEG = 6, FAST = 5000, SLOW = 50000, SMIN = 150, SMAX = 500;
  localparam logic [2:0] HI = 3'b101, LO = 3'b010;

  logic clk = 1'b0, rstN = 1'b0, switchEvt = 1'b0;
  logic [2:0] ocRaw = '0;
  logic uvRaw = 0, ovRaw = 0, cpuvRaw = 0, otsRaw = 0, otwRaw = 0, otwEn = 0;
  logic retryFast = 1'b1, sleepN = 1'b1;
  logic [2:0] hiDemand = HI, loDemand = LO, hiGate, loGate;
  logic faultN, sleeping;
  int nChk = 0, nFail = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mfault_sup #(.CLK_HZ(HZ), .NUM_PH(3)) u_mfault_sup (
    .clk(clk), .rstN(rstN), .switchEvt(switchEvt), .ocRaw(ocRaw), .uvRaw(uvRaw),
    .ovRaw(ovRaw), .cpuvRaw(cpuvRaw), .otsRaw(otsRaw), .otwRaw(otwRaw), .otwEn(otwEn),
    .retryFast(retryFast), .sleepN(sleepN), .hiDemand(hiDemand), .loDemand(loDemand),
    .hiGate(hiGate), .loGate(loGate), .faultN(faultN), .sleeping(sleeping)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected {hiGate, loGate, faultN, sleeping}
  function automatic logic [31:0] obs();
    return {24'd0, hiGate, loGate, faultN, sleeping};
  endfunction
  function automatic logic [31:0] want(input bit en, input bit fn, input bit sl);
    return {24'd0, en ? HI : 3'b0, en ? LO : 3'b0, fn, sl};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    wait (cyc > 190_000);
    nChk++; nFail++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 190_000);
    finish_run();
  end

  initial begin
    step(3); rstN = 1'b1; step(1);
    chk("R11 reset state", obs(), want(1, 1, 0));
    hiDemand = 3'b011; loDemand = 3'b100; step(1);
    chk("R10 demand pass-through", {24'd0, hiGate, loGate, 2'b00}, {24'd0, 3'b011, 3'b100, 2'b00});
    hiDemand = HI; loDemand = LO;

    // R2 deglitch threshold
    ocRaw = 3'b001; step(DEG - 1); ocRaw = '0; step(1);
    chk("R2 short over-current ignored", obs(), want(1, 1, 0));
    ocRaw = 3'b010; step(DEG); ocRaw = '0; step(1);
    chk("R2 over-current latched / R5 faultN low", obs(), want(0, 0, 0));
    step(FAST - 1);
    chk("R4 fast retry not early", obs(), want(0, 0, 0));
    step(1);
    chk("R4 fast retry release / R5 faultN high", obs(), want(1, 1, 0));

    // R1 blanking
    switchEvt = 1; ocRaw = 3'b100; step(1); switchEvt = 0;
    step(BLANK + DEG - 1); ocRaw = '0; step(1);
    chk("R1 blanked over-current ignored", obs(), want(1, 1, 0));
    switchEvt = 1; ocRaw = 3'b100; step(1); switchEvt = 0;
    step(BLANK + DEG); ocRaw = '0; step(1);
    chk("R1 over-current after blank latched", obs(), want(0, 0, 0));
    step(FAST);

    // R3 each level source
    for (int s = 0; s < 4; s++) begin
      {uvRaw, ovRaw, cpuvRaw, otsRaw} = 4'b1000 >> s; step(1);
      {uvRaw, ovRaw, cpuvRaw, otsRaw} = '0;
      chk($sformatf("R3 level source %0d shuts down", s), obs(), want(0, 0, 0));
      step(FAST - 1);
      chk($sformatf("R4 source %0d held", s), obs(), want(0, 0, 0));
      step(1);
      chk($sformatf("R4 source %0d released", s), obs(), want(1, 1, 0));
    end

    // R4 persistent source restarts the interval
    uvRaw = 1; step(100); uvRaw = 0;
    step(FAST - 1);
    chk("R4 restart held", obs(), want(0, 0, 0));
    step(1);
    chk("R4 restart released", obs(), want(1, 1, 0));

    // R4 slow interval
    retryFast = 0; ovRaw = 1; step(1); ovRaw = 0; retryFast = 1;
    step(SLOW - 1);
    chk("R4 slow retry not early", obs(), want(0, 0, 0));
    step(1);
    chk("R4 slow retry release", obs(), want(1, 1, 0));

    // R6 warning
    otwEn = 1; otwRaw = 1; #1;
    chk("R6 warning pulls faultN only", obs(), want(1, 0, 0));
    otwEn = 0; #1;
    chk("R6 disabled warning no effect", obs(), want(1, 1, 0));
    otwRaw = 0; step(1);

    // R7 / R8 sleep pulses
    cpuvRaw = 1; step(1); cpuvRaw = 0;
    sleepN = 0; step(SMIN - 1); sleepN = 1; step(2);
    chk("R7 short sleep pulse ignored", obs(), want(0, 0, 0));
    sleepN = 0; step(SMIN); sleepN = 1; step(1);
    chk("R8 minimum clear pulse", obs(), want(1, 1, 0));
    otsRaw = 1; step(1); otsRaw = 0;
    sleepN = 0; step(SMAX); sleepN = 1; step(1);
    chk("R8 maximum clear pulse", obs(), want(1, 1, 0));

    // R9 long low enters sleep
    uvRaw = 1; step(1); uvRaw = 0;
    sleepN = 0; step(SMAX);
    chk("R9 not yet asleep", obs(), want(0, 0, 0));
    step(1);
    chk("R9 asleep", obs(), want(0, 0, 1));
    step(3); sleepN = 1; step(1);
    chk("R9 wake clears fault", obs(), want(1, 1, 0));

    finish_run();
  end
endmodule